// File: doc/BRIEF.md
# Coprocessor Instruction Handshake Controller

This block is the processor-side sequencer that hands one instruction to an external coprocessor. A single-cycle request from the pipeline starts a handshake. While the handshake is open, the block holds an active-low instruction strobe low and freezes the pipeline through a stall output.

The coprocessor answers on two active-high lines, `absent` and `busy`. The `absent` line is looked at only once, on the first rising edge after the handshake opens. If it is high, the handshake is dropped and a one-cycle trap pulse asks for the undefined-instruction trap. If it is low, the block waits for as long as `busy` stays high and then gives a one-cycle completion pulse. Decoding the instruction, moving coprocessor data and vectoring the trap are done elsewhere.

Top module: `cop_handshake`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, the strobe is high and stall, done and trap are low.
- R2: A request sampled high on a rising edge while the block is idle makes the strobe go low and stall go high from that edge on.
- R3: If `absent` is high on the rising edge that follows the one that opened the handshake (the decision edge), trap is high for the next cycle. In that cycle the strobe is high and stall is low.
- R4: If `absent` is low and `busy` is high at the decision edge, the block busy-waits. The strobe stays low and stall stays high on every edge at which `busy` is sampled high.
- R5: The first rising edge in the busy-wait at which `busy` is sampled low raises done for the next cycle. In that cycle the strobe is high and stall is low.
- R6: If `absent` and `busy` are both low at the decision edge, done rises in the next cycle with no busy-wait cycles.
- R7: done and trap each last exactly one cycle, after which the block is idle (strobe high, stall, done and trap low). At most one of stall, done and trap is high at any time.
- R8: A request that arrives while the block is not idle is ignored: it neither opens a new handshake nor lengthens the current one.
- R9: `absent` is ignored after the decision edge; a high `absent` during the busy-wait does not raise trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request from the pipeline to start a handshake |
| cp_absent_i | input | 1 | Coprocessor response: high means no coprocessor takes the instruction |
| cp_busy_i | input | 1 | Coprocessor response: high means the coprocessor is still working |
| cop_instr_no | output | 1 | Coprocessor instruction strobe, low while a handshake is open |
| stall_o | output | 1 | Pipeline freeze, high while a handshake is open |
| done_o | output | 1 | One-cycle pulse: the coprocessor completed the instruction |
| trap_o | output | 1 | One-cycle pulse: handshake aborted, take the undefined-instruction trap |

## Verification
Assertions check on every cycle that each decision-edge outcome (trap, direct completion, busy-wait) leads to the right next state. They also check that a busy-wait lasts while `busy` is high, that completion and trap pulses are one cycle long and return to idle even when a request is present, and that stall, done and trap never overlap. Only the bench's scenarios can show the whole sequence seen at the ports. That covers the exact cycle of each output change for busy-waits of different lengths, the effect of reset in the middle of a handshake, and that stray requests and a late `absent` leave the outcome and its timing unchanged.

// File: rtl/cop_hs_pkg.sv
package cop_hs_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_DONE = 3'd3,
    ST_TRAP = 3'd4
  } hs_state_e;
endpackage

// File: rtl/cop_hs_fsm.sv
module cop_hs_fsm
  import cop_hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      absent_i,
  input  logic      busy_i,
  output hs_state_e state_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_REQ;
      // decision edge: absent sampled only here
      ST_REQ: begin
        if (absent_i)     state_d = ST_TRAP;
        else if (busy_i)  state_d = ST_WAIT;
        else              state_d = ST_DONE;
      end
      ST_WAIT: if (!busy_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_TRAP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i) |=> (state_q == ST_REQ));
  assert_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && absent_i) |=> (state_q == ST_TRAP));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && busy_i) |=> (state_q == ST_WAIT));
  assert_finish_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !busy_i) |=> (state_q == ST_DONE));
  assert_direct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && !absent_i && !busy_i) |=> (state_q == ST_DONE));
  assert_late_absent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> (state_q != ST_TRAP));
endmodule

// File: rtl/cop_hs_decode.sv
module cop_hs_decode
  import cop_hs_pkg::*;
(
  input  hs_state_e state_i,
  output logic      strobe_no,
  output logic      stall_o,
  output logic      done_o,
  output logic      trap_o
);
  logic open_hs;

  assign open_hs   = (state_i == ST_REQ) || (state_i == ST_WAIT);
  assign strobe_no = !open_hs;
  assign stall_o   = open_hs;
  assign done_o    = (state_i == ST_DONE);
  assign trap_o    = (state_i == ST_TRAP);
endmodule

// File: rtl/cop_handshake.sv
module cop_handshake
  import cop_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cp_absent_i,
  input  logic cp_busy_i,
  output logic cop_instr_no,
  output logic stall_o,
  output logic done_o,
  output logic trap_o
);
  hs_state_e state;

  cop_hs_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .absent_i (cp_absent_i),
    .busy_i   (cp_busy_i),
    .state_o  (state)
  );

  cop_hs_decode u_dec (
    .state_i   (state),
    .strobe_no (cop_instr_no),
    .stall_o   (stall_o),
    .done_o    (done_o),
    .trap_o    (trap_o)
  );

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stall_o, done_o, trap_o}));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !stall_o && cop_instr_no));
  assert_trap_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (!trap_o && !stall_o && cop_instr_no));
  assert_busy_ignores_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !cp_absent_i && cp_busy_i && !done_o) |=> stall_o);
endmodule

// File: tb/cop_handshake_test.sv
module cop_handshake_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, absent = 1'b0, busy = 1'b0;
  logic strobe_n, stall, done, trap;
  int   total = 0, bad = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cop_handshake uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .cp_absent_i(absent), .cp_busy_i(busy),
    .cop_instr_no(strobe_n), .stall_o(stall), .done_o(done), .trap_o(trap)
  );

  // output vector {strobe_n, stall, done, trap}
  localparam logic [3:0] V_IDLE = 4'b1000;
  localparam logic [3:0] V_OPEN = 4'b0100;
  localparam logic [3:0] V_DONE = 4'b1010;
  localparam logic [3:0] V_TRAP = 4'b1001;

  function automatic logic [3:0] outcome(input bit a, input int n);
    if (a) return V_TRAP;
    return V_DONE;
  endfunction

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {strobe_n, stall, done, trap};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // n = busy-wait cycles; junk = stray requests and late absent
  task automatic handshake(input bit a, input int n, input bit junk);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    chk("R2 open", V_OPEN);
    req = junk;
    absent = a;
    busy = (n > 0);
    for (int k = 1; k <= n && !a; k++) begin
      @(negedge clk);
      chk("R4 busy-wait", V_OPEN);
      busy = (k < n);
      absent = junk ? 1'($urandom_range(0, 1)) : 1'b0;  // R9
      req = junk ? 1'($urandom_range(0, 1)) : 1'b0;     // R8
    end
    @(negedge clk);
    if (a)           chk("R3 trap", outcome(a, n));
    else if (n == 0) chk("R6 direct done", outcome(a, n));
    else             chk("R5 done", outcome(a, n));
    req = junk;  // R8: request during pulse ignored
    absent = 1'b0;
    busy = 1'b0;
    @(negedge clk);
    chk("R7 back to idle", V_IDLE);
    req = 1'b0;
    @(negedge clk);
    chk("R8 no new handshake", V_IDLE);
  endtask

  initial begin
    void'($urandom(32'd1357));
    #1;
    chk("R1 in reset", V_IDLE);
    repeat (3) @(negedge clk);
    chk("R1 in reset", V_IDLE);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", V_IDLE);

    handshake(1'b1, 0, 1'b0);  // R3 abort
    handshake(1'b0, 0, 1'b0);  // R6 direct
    handshake(1'b0, 1, 1'b0);  // R5 minimal wait
    handshake(1'b0, 4, 1'b1);  // R8/R9 noise
    handshake(1'b1, 3, 1'b1);  // R3 busy ignored under absent

    // R1: reset mid busy-wait
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0; busy = 1'b1;
    @(negedge clk); chk("R4 wait before reset", V_OPEN);
    rst_ni = 1'b0; #1;
    chk("R1 reset aborts", V_IDLE);
    @(negedge clk); rst_ni = 1'b1; busy = 1'b0;
    @(negedge clk); chk("R1 idle after reset", V_IDLE);

    for (int i = 0; i < 60; i++)
      handshake(1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 6)),
                1'($urandom_range(0, 1)));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule